// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block turns one decoded addressing request of a small 8-bit processor into a 16-bit data-memory address. It also produces the value the X index register should take after the access. The decoder presents the addressing mode, the operand bytes taken from the instruction, the current X value, a page-enable flag and a page register, together with a one-cycle request strobe. One clock later the block raises `valid_o` with the address and the updated X.

Absolute requests pass the 16-bit operand straight through. Every other mode builds the address from two bytes. The upper byte is the page byte: it is the page register when the flag is set, and zero when it is clear. The lower byte comes from X, either alone or added to an 8-bit offset.

The post-increment mode reads memory at the current X and then advances X by one. Only accumulator load and store instructions may use it. The decoder states this with a qualifier input. When that qualifier is low, the block uses the address but leaves X alone.

Top module: `dpag_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `valid_o` and `x_we_o` are 0 and `addr_o` and `x_o` are all zeros.
- R2: `valid_o` is 1 in exactly those cycles that follow a rising clock edge at which `req_i` was sampled 1.
- R3: Mode code 2'b00 (absolute) gives `addr_o` equal to `opnd_i`, whatever `pg_en_i` and `pg_reg_i` hold.
- R4: For mode codes 2'b01, 2'b10 and 2'b11, `addr_o[15:8]` equals `pg_reg_i` when `pg_en_i` is 1, and 8'h00 when it is 0.
- R5: Mode code 2'b01 (X-indirect) gives `addr_o[7:0]` equal to `x_i`.
- R6: Mode code 2'b10 (X-indirect with post-increment) with `acc_move_i` at 1 gives `addr_o[7:0]` equal to the X value before the increment, with `x_o` equal to `x_i + 1` and `x_we_o` at 1, all in the same cycle as `valid_o`.
- R7: The post-increment wraps within 8 bits, so `x_i` = 8'hFF yields `x_o` = 8'h00 and leaves the page byte unchanged.
- R8: Mode code 2'b11 (direct page plus X) gives `addr_o[7:0]` equal to `(opnd_i[7:0] + x_i) mod 256`, and no carry reaches the page byte.
- R9: Every mode other than 2'b10, and mode 2'b10 with `acc_move_i` at 0, produces `x_we_o` at 0 and `x_o` equal to `x_i`.
- R10: In a cycle after an edge at which `req_i` was 0, `addr_o` and `x_o` keep their previous values and `x_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one address computation per cycle it is high |
| mode_i | input | 2 | Addressing mode: 00 absolute, 01 X-indirect, 10 X-indirect post-increment, 11 direct page plus X |
| opnd_i | input | 16 | Instruction operand; the full word for absolute, the low byte as offset for mode 11 |
| x_i | input | 8 | Current X index register |
| pg_en_i | input | 1 | Page-enable flag |
| pg_reg_i | input | 8 | Page register, used as the upper byte when the flag is set |
| acc_move_i | input | 1 | Decoder qualifier: the instruction is an accumulator load or store |
| valid_o | output | 1 | Result valid, one cycle after the request |
| addr_o | output | 16 | Effective address |
| x_o | output | 8 | X value after the access |
| x_we_o | output | 1 | X write-back enable |

## Verification
The bench replays the two worked cases, page register 01h with flag set and X = 15h, and flag clear with X = 35h. These show that the page byte follows the flag and not the page register alone. Absolute requests are sent with a nonzero page register and the flag set, to prove the page logic is bypassed. Offsets whose sum with X overflows 8 bits, and a post-increment from FFh, separate true 8-bit wrap from a carry into the page byte. Post-increment requests with the qualifier low, idle gaps between requests, and a long random mix of all inputs separate write-back gating and output holding from the address path, checked against a behavioural model every clock.

// File: rtl/dpag_pkg.sv
package dpag_pkg;

  // Addressing mode codes as issued by the instruction decoder.
  typedef enum logic [1:0] {
    AM_ABS  = 2'b00,
    AM_XIND = 2'b01,
    AM_XINC = 2'b10,
    AM_DPX  = 2'b11
  } am_e;

endpackage

// File: rtl/dpag_page_sel.sv
// Upper address byte for the paged modes.
module dpag_page_sel #(
  parameter int DATA_W = 8
) (
  input  logic              pg_en,
  input  logic [DATA_W-1:0] pg_reg,
  output logic [DATA_W-1:0] hi
);

  function automatic logic [DATA_W-1:0] page_byte(input logic en,
                                                  input logic [DATA_W-1:0] reg_v);
    return en ? reg_v : '0;
  endfunction

  assign hi = page_byte(pg_en, pg_reg);

endmodule

// File: rtl/dpag_low_gen.sv
// Lower address byte and X side effect for the paged modes.
module dpag_low_gen
  import dpag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  am_e               mode,
  input  logic [DATA_W-1:0] off,
  input  logic [DATA_W-1:0] x,
  input  logic              acc_move,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] x_next,
  output logic              x_we
);

  // Sum truncated to DATA_W bits: no carry leaves the byte.
  function automatic logic [DATA_W-1:0] dp_sum(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] x_bump(input logic [DATA_W-1:0] v);
    return v + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic bump_ok;
  assign bump_ok = (mode == AM_XINC) && acc_move;

  always_comb begin
    unique case (mode)
      AM_DPX:  lo = dp_sum(off, x);
      default: lo = x;
    endcase
  end

  assign x_next = bump_ok ? x_bump(x) : x;
  assign x_we   = bump_ok;

endmodule

// File: rtl/dpag_core.sv
module dpag_core
  import dpag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [1:0]            mode_i,
  input  logic [2*DATA_W-1:0]   opnd_i,
  input  logic [DATA_W-1:0]     x_i,
  input  logic                  pg_en_i,
  input  logic [DATA_W-1:0]     pg_reg_i,
  input  logic                  acc_move_i,
  output logic                  valid_o,
  output logic [2*DATA_W-1:0]   addr_o,
  output logic [DATA_W-1:0]     x_o,
  output logic                  x_we_o
);

  localparam int ADDR_W = 2 * DATA_W;

  am_e               mode;
  logic [DATA_W-1:0] page_hi;
  logic [DATA_W-1:0] low_b;
  logic [DATA_W-1:0] x_nxt;
  logic              x_we_nxt;
  logic [ADDR_W-1:0] ea_nxt;
  logic              req_fire;
  logic              is_abs;

  assign mode     = am_e'(mode_i);
  assign req_fire = req_i;
  assign is_abs   = (mode == AM_ABS);

  dpag_page_sel #(.DATA_W(DATA_W)) u_page (
    .pg_en  (pg_en_i),
    .pg_reg (pg_reg_i),
    .hi     (page_hi)
  );

  dpag_low_gen #(.DATA_W(DATA_W)) u_low (
    .mode     (mode),
    .off      (opnd_i[DATA_W-1:0]),
    .x        (x_i),
    .acc_move (acc_move_i),
    .lo       (low_b),
    .x_next   (x_nxt),
    .x_we     (x_we_nxt)
  );

  assign ea_nxt = is_abs ? opnd_i : {page_hi, low_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      x_o     <= '0;
      x_we_o  <= 1'b0;
    end else begin
      valid_o <= req_fire;
      x_we_o  <= req_fire & x_we_nxt;
      if (req_fire) begin
        addr_o <= ea_nxt;
        x_o    <= x_nxt;
      end
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o); // R2
  AST_ABS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 2'b00) |=> addr_o == $past(opnd_i)); // R3
  AST_PAGE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i != 2'b00) |=>
      addr_o[ADDR_W-1:DATA_W] == ($past(pg_en_i) ? $past(pg_reg_i) : '0)); // R4
  AST_XINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == 2'b10 && acc_move_i) |=>
      (x_we_o && x_o == DATA_W'($past(x_i) + 1'b1))); // R6
  AST_XWE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    x_we_o |-> valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(addr_o) && $stable(x_o) && !x_we_o)); // R10

endmodule

// File: tb/test_dpag_core.sv
`timescale 1ns/1ps
module test_dpag_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [15:0] opnd_i = '0;
  logic [7:0]  x_i = '0;
  logic        pg_en_i = 1'b0;
  logic [7:0]  pg_reg_i = '0;
  logic        acc_move_i = 1'b0;
  logic        valid_o;
  logic [15:0] addr_o;
  logic [7:0]  x_o;
  logic        x_we_o;

  always #4 clk = ~clk; // 125 MHz

  dpag_core i_dpag_core (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .opnd_i(opnd_i), .x_i(x_i), .pg_en_i(pg_en_i), .pg_reg_i(pg_reg_i),
    .acc_move_i(acc_move_i), .valid_o(valid_o), .addr_o(addr_o),
    .x_o(x_o), .x_we_o(x_we_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model state.
  int exp_valid = 0, exp_addr = 0, exp_x = 0, exp_we = 0;
  int last_mode = -1;  // -1: no request in the last cycle
  int last_x_in = 0;
  int last_acc  = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (req_i) begin
        int pg, lo, xin;
        xin = int'(x_i);
        pg  = pg_en_i ? int'(pg_reg_i) : 0;
        if (mode_i == 2'd3) lo = (int'(opnd_i[7:0]) + xin) % 256;
        else lo = xin;
        exp_addr  = (mode_i == 2'd0) ? int'(opnd_i) : pg * 256 + lo;
        exp_valid = 1;
        if (mode_i == 2'd2 && acc_move_i) begin
          exp_x = (xin + 1) % 256; exp_we = 1;
        end else begin
          exp_x = xin; exp_we = 0;
        end
        last_mode = int'(mode_i); last_x_in = xin; last_acc = int'(acc_move_i);
      end else begin
        exp_valid = 0; exp_we = 0; last_mode = -1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    string atag, xtag;
    check("R2 valid", int'(valid_o), exp_valid);
    case (last_mode)
      0: atag = "R3 absolute addr";
      1: atag = "R5 x-indirect addr";
      2: atag = "R6 post-inc addr";
      3: atag = "R8 dp+x addr";
      default: atag = "R10 held addr";
    endcase
    check(atag, int'(addr_o), exp_addr);
    if (last_mode > 0) check("R4 page byte", int'(addr_o[15:8]), exp_addr / 256);
    if (last_mode == 2 && last_acc == 1)
      xtag = (last_x_in == 255) ? "R7 x wrap" : "R6 x increment";
    else if (last_mode >= 0) xtag = "R9 x untouched";
    else xtag = "R10 held x";
    check(xtag, int'(x_o), exp_x);
    check((last_mode >= 0) ? "R9 x write enable" : "R10 x write enable",
          int'(x_we_o), exp_we);
  endtask

  task automatic issue(input bit rq, input int md, input int op, input int xv,
                       input bit ge, input int pr, input bit acc);
    @(negedge clk);
    compare_all();
    req_i = rq; mode_i = 2'(md); opnd_i = 16'(op); x_i = 8'(xv);
    pg_en_i = ge; pg_reg_i = 8'(pr); acc_move_i = acc;
  endtask

  initial begin
    #1;
    check("R1 reset valid", int'(valid_o), 0);
    check("R1 reset addr", int'(addr_o), 0);
    check("R1 reset x", int'(x_o), 0);
    check("R1 reset we", int'(x_we_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Worked cases: paged X-indirect, then page zero.
    issue(1, 1, 16'h0000, 8'h15, 1, 8'h01, 0);
    issue(1, 1, 16'h0000, 8'h35, 0, 8'h01, 0);
    issue(1, 2, 16'h0000, 8'h35, 0, 8'h7F, 1);
    // Absolute ignores page controls.
    issue(1, 0, 16'h0135, 8'h44, 1, 8'hAA, 1);
    issue(1, 0, 16'hF035, 8'h00, 0, 8'h00, 0);
    // dp+X with and without wrap, both page settings.
    issue(1, 3, 16'h00F0, 8'h20, 0, 8'h05, 0);
    issue(1, 3, 16'h12F0, 8'h20, 1, 8'h05, 0);
    issue(1, 3, 16'h0010, 8'hF5, 1, 8'hE0, 0);
    // Post-increment wrap and qualifier low.
    issue(1, 2, 16'h0000, 8'hFF, 1, 8'h03, 1);
    issue(1, 2, 16'h0000, 8'h80, 1, 8'h03, 0);
    // Idle gap with changing inputs.
    issue(0, 2, 16'hBEEF, 8'h11, 1, 8'h22, 1);
    issue(0, 3, 16'h1234, 8'h99, 0, 8'h00, 0);
    for (int i = 0; i < 400; i++)
      issue(bit'($urandom_range(0, 3) != 0), $urandom_range(0, 3),
            $urandom_range(0, 65535),
            ($urandom_range(0, 7) == 0) ? 255 : $urandom_range(0, 255),
            bit'($urandom_range(0, 1)), $urandom_range(0, 255),
            bit'($urandom_range(0, 1)));
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule